// File: doc/BRIEF.md
# Cross-Clock Timer Register Bridge

This block sits between a processor running on a system clock and an 8-bit counter running on an unrelated timer clock. The processor writes three timer registers: the live count, the compare value and a control byte whose bit 0 starts and stops counting. A write never reaches the timer directly. It goes into a holding register on the system side. A request toggle then carries it across, and the timer side loads its own copy. An acknowledge toggle comes back, and only then does that register's busy flag fall. While a register is busy, the processor must wait before writing it again. A write issued during that window is dropped and raises a sticky error bit.

Reads follow two rules. Reading the count returns the value the counter actually holds, passed to the system clock in Gray code. Reading compare or control returns the holding register, so software sees its last accepted write at once. The timer also reports two events. A compare event fires when a counting tick finds the count equal to the compare copy. An overflow event fires when a tick wraps the count from all ones to zero. Each event sets a system-side flag. A flag raises an interrupt request only when its mask bit and the global enable input are also set.

Each transfer channel is a two-state machine. `X_IDLE` moves to `X_WAIT` on an accepted write. `X_WAIT` returns to `X_IDLE` when the returned acknowledge equals the request toggle. A write seen in `X_WAIT` stays in `X_WAIT` and is rejected.

Top module: `async_timer_bridge`

## Requirements
- R1: A write to address 0 (count), 1 (compare) or 2 (control) sets that register's busy bit in the status byte at address 3 (bit 2 count, bit 1 compare, bit 0 control) from the next system cycle.
- R2: The busy bit clears by itself once the timer-side copy has been loaded, within 40 system cycles at the default clocks.
- R3: A read of address 0 returns the timer's live count: a loaded value when stopped, a value that keeps changing while control bit 0 is one.
- R4: Reads of address 1 and 2 return the holding register, already updated in the cycle after the write and while it is still busy.
- R5: The flag byte at address 4 sets bit 1 when a counting tick finds count equal to compare, and bit 0 when a tick wraps the count 0xFF to 0x00.
- R6: Writing a one to a flag bit at address 4 clears that bit; writing zero leaves it unchanged.
- R7: A pulse on the acknowledge input of a flag clears that flag.
- R8: The mask byte at address 5 uses bit 1 for compare and bit 0 for overflow; an interrupt output is high only when its flag, its mask bit and the global enable are all one.
- R9: A write to a busy register is ignored, and the holding value is kept. It sets the sticky status bit 3, which is cleared by writing a one to bit 3 at address 3.
- R10: After reset, every holding register, flag, mask, busy and error bit and both interrupt outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Processor clock |
| sys_rst_n | input | 1 | Active-low reset, system side |
| tmr_clk | input | 1 | Timer clock, unrelated to sys_clk |
| tmr_rst_n | input | 1 | Active-low reset, timer side |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| gie | input | 1 | Global interrupt enable |
| ack_match | input | 1 | Compare interrupt acknowledge |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| irq_match | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
Suppose a channel machine sticks in `X_WAIT`. Its status bit then never falls, and the bench sees this within the 40-cycle polling window. Suppose instead it returns to `X_IDLE` too early. Then a count read a few cycles later still shows the old value, or a second write is accepted where it should have raised the error bit. Lost event toggles show up as flags still at zero after a run through the wrap and compare points, about 30 cycles later. A wrong clear or gating term shows up at the very next read of the flag byte or the interrupt pins.

// File: rtl/atb_pkg.sv
package atb_pkg;
    localparam int DW  = 8;
    localparam int NCH = 3;
    localparam int CH_CTL = 0;
    localparam int CH_CMP = 1;
    localparam int CH_CNT = 2;

    typedef enum logic [2:0] {
        A_CNT  = 3'd0,
        A_CMP  = 3'd1,
        A_CTL  = 3'd2,
        A_STAT = 3'd3,
        A_FLAG = 3'd4,
        A_MASK = 3'd5
    } addr_e;

    typedef enum logic {
        X_IDLE = 1'b0,
        X_WAIT = 1'b1
    } xfer_st_e;

    function automatic logic [DW-1:0] gray2bin(input logic [DW-1:0] g);
        logic [DW-1:0] b;
        b[DW-1] = g[DW-1];
        for (int i = DW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/atb_sync.sv
module atb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/atb_xfer_sys.sv
module atb_xfer_sys
    import atb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack_s,
    output logic [W-1:0] hold,
    output logic         req_tgl,
    output logic         busy,
    output logic         reject
);
    xfer_st_e st_q, st_d;
    logic     accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= X_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            X_IDLE: if (wr) st_d = X_WAIT;
            X_WAIT: if (ack_s == req_tgl) st_d = X_IDLE;
            default: st_d = X_IDLE;
        endcase
    end

    always_comb begin
        busy   = (st_q == X_WAIT);
        accept = wr && (st_q == X_IDLE);
        reject = wr && (st_q == X_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold    <= '0;
            req_tgl <= 1'b0;
        end else if (accept) begin
            hold    <= wdata;
            req_tgl <= ~req_tgl;
        end
    end
endmodule

// File: rtl/atb_xfer_tmr.sv
module atb_xfer_tmr (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic load,
    output logic ack_tgl
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= req_s;
    end

    assign load    = req_s ^ seen_q;
    assign ack_tgl = seen_q;
endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core
    import atb_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_cnt,
    input  logic         ld_cmp,
    input  logic         ld_ctl,
    input  logic [W-1:0] d_cnt,
    input  logic [W-1:0] d_cmp,
    input  logic [W-1:0] d_ctl,
    output logic [W-1:0] cnt_gray,
    output logic         match_tgl,
    output logic         ovf_tgl
);
    logic [W-1:0] cnt_q, cmp_q, ctl_q;
    logic         tick;

    assign tick = ctl_q[0] && !ld_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
            ctl_q <= '0;
        end else begin
            if (ld_cnt)    cnt_q <= d_cnt;
            else if (tick) cnt_q <= cnt_q + 1'b1;
            if (ld_cmp)    cmp_q <= d_cmp;
            if (ld_ctl)    ctl_q <= d_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_tgl <= 1'b0;
            ovf_tgl   <= 1'b0;
            cnt_gray  <= '0;
        end else begin
            if (tick && cnt_q == cmp_q) match_tgl <= ~match_tgl;
            if (tick && cnt_q == '1)    ovf_tgl   <= ~ovf_tgl;
            cnt_gray <= cnt_q ^ (cnt_q >> 1);
        end
    end
endmodule

// File: rtl/atb_flag_unit.sv
module atb_flag_unit #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] ev_s,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] evt,
    output logic [NF-1:0] flag
);
    logic [NF-1:0] ev_prev;

    assign evt = ev_s ^ ev_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_prev <= '0;
            flag    <= '0;
        end else begin
            ev_prev <= ev_s;
            flag    <= evt | (flag & ~clr);
        end
    end
endmodule

// File: rtl/async_timer_bridge.sv
module async_timer_bridge
    import atb_pkg::*;
(
    input  logic          sys_clk,
    input  logic          sys_rst_n,
    input  logic          tmr_clk,
    input  logic          tmr_rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          gie,
    input  logic          ack_match,
    input  logic          ack_ovf,
    output logic          irq_match,
    output logic          irq_ovf
);
    logic [DW-1:0]  hold [NCH];
    logic [NCH-1:0] busy, reject, req_tgl, req_s, ack_tgl, ack_s, load, ch_wr;
    logic           err_q;
    logic [1:0]     flag, evt, ev_s, ev_t, flag_clr;
    logic [1:0]     mask_q;
    logic [DW-1:0]  gray_t, gray_s, cnt_live;
    logic [DW-1:0]  hold_cmp;

    assign ch_wr[CH_CNT] = wr_en && (addr == A_CNT);
    assign ch_wr[CH_CMP] = wr_en && (addr == A_CMP);
    assign ch_wr[CH_CTL] = wr_en && (addr == A_CTL);
    assign hold_cmp      = hold[CH_CMP];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        atb_xfer_sys #(.W(DW)) u_xs (
            .clk(sys_clk), .rst_n(sys_rst_n), .wr(ch_wr[c]), .wdata(wdata),
            .ack_s(ack_s[c]), .hold(hold[c]), .req_tgl(req_tgl[c]),
            .busy(busy[c]), .reject(reject[c])
        );
        atb_sync #(.W(1)) u_req_sync (
            .clk(tmr_clk), .rst_n(tmr_rst_n), .d(req_tgl[c]), .q(req_s[c])
        );
        atb_xfer_tmr u_xt (
            .clk(tmr_clk), .rst_n(tmr_rst_n), .req_s(req_s[c]),
            .load(load[c]), .ack_tgl(ack_tgl[c])
        );
        atb_sync #(.W(1)) u_ack_sync (
            .clk(sys_clk), .rst_n(sys_rst_n), .d(ack_tgl[c]), .q(ack_s[c])
        );
    end

    atb_tmr_core #(.W(DW)) u_core (
        .clk(tmr_clk), .rst_n(tmr_rst_n),
        .ld_cnt(load[CH_CNT]), .ld_cmp(load[CH_CMP]), .ld_ctl(load[CH_CTL]),
        .d_cnt(hold[CH_CNT]), .d_cmp(hold[CH_CMP]), .d_ctl(hold[CH_CTL]),
        .cnt_gray(gray_t), .match_tgl(ev_t[1]), .ovf_tgl(ev_t[0])
    );

    atb_sync #(.W(DW)) u_gray_sync (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(gray_t), .q(gray_s)
    );
    assign cnt_live = gray2bin(gray_s);

    atb_sync #(.W(2)) u_ev_sync (
        .clk(sys_clk), .rst_n(sys_rst_n), .d(ev_t), .q(ev_s)
    );

    assign flag_clr = ({2{wr_en && addr == A_FLAG}} & wdata[1:0]) | {ack_match, ack_ovf};

    atb_flag_unit #(.NF(2)) u_flags (
        .clk(sys_clk), .rst_n(sys_rst_n), .ev_s(ev_s), .clr(flag_clr),
        .evt(evt), .flag(flag)
    );

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            err_q  <= 1'b0;
            mask_q <= '0;
        end else begin
            if (|reject)                                    err_q <= 1'b1;
            else if (wr_en && addr == A_STAT && wdata[3])   err_q <= 1'b0;
            if (wr_en && addr == A_MASK)                    mask_q <= wdata[1:0];
        end
    end

    assign irq_match = flag[1] & mask_q[1] & gie;
    assign irq_ovf   = flag[0] & mask_q[0] & gie;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CNT:   rdata = cnt_live;
            A_CMP:   rdata = hold[CH_CMP];
            A_CTL:   rdata = hold[CH_CTL];
            A_STAT:  rdata = {4'b0, err_q, busy[CH_CNT], busy[CH_CMP], busy[CH_CTL]};
            A_FLAG:  rdata = {6'b0, flag};
            A_MASK:  rdata = {6'b0, mask_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/atb_checker.sv
module atb_checker (
    input logic       sys_clk,
    input logic       sys_rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [2:0] busy,
    input logic       err_q,
    input logic [1:0] flag,
    input logic [1:0] evt,
    input logic       ack_ovf,
    input logic [7:0] hold_cmp
);
    p_busy_set_r1: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && addr == 3'd1 && !busy[1]) |=> busy[1]);

    p_busy_cnt_r1: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && addr == 3'd0 && !busy[2]) |=> busy[2]);

    p_event_sets_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        evt[1] |=> flag[1]);

    p_w1c_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && addr == 3'd4 && wdata[1] && !evt[1]) |=> !flag[1]);

    p_ack_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (ack_ovf && !evt[0]) |=> !flag[0]);

    p_hold_kept_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && addr == 3'd1 && busy[1]) |=> $stable(hold_cmp));

    p_err_raise_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (wr_en && addr == 3'd2 && busy[0]) |=> err_q);

    p_err_sticky_r9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (err_q && !(wr_en && addr == 3'd3 && wdata[3])) |=> err_q);
endmodule

bind async_timer_bridge atb_checker u_chk (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .busy(busy), .err_q(err_q), .flag(flag), .evt(evt),
    .ack_ovf(ack_ovf), .hold_cmp(hold_cmp)
);

// File: tb/async_timer_bridge_tb.sv
module async_timer_bridge_tb;
    import atb_pkg::*;

    logic       sys_clk = 1'b0, tmr_clk = 1'b0;
    logic       sys_rst_n = 1'b0, tmr_rst_n = 1'b0;
    logic       wr_en = 1'b0, gie = 1'b0, ack_match = 1'b0, ack_ovf = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_match, irq_ovf;
    int         n_chk = 0, n_fail = 0;

    always #4    sys_clk = ~sys_clk;
    always #6.5  tmr_clk = ~tmr_clk;

    async_timer_bridge u_dut (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .gie(gie),
        .ack_match(ack_match), .ack_ovf(ack_ovf), .irq_match(irq_match), .irq_ovf(irq_ovf)
    );

    // {address, write data, expected read-back}
    localparam logic [18:0] VEC [10] = '{
        {3'd5, 8'h03, 8'h03},
        {3'd5, 8'hFE, 8'h02},
        {3'd1, 8'h5A, 8'h5A},
        {3'd2, 8'hA4, 8'hA4},
        {3'd0, 8'h3C, 8'h3C},
        {3'd0, 8'h00, 8'h00},
        {3'd1, 8'hFF, 8'hFF},
        {3'd3, 8'h00, 8'h00},
        {3'd4, 8'h03, 8'h00},
        {3'd5, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge sys_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge sys_clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge sys_clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        int         n;
        n = 0;
        rd(3'd3, s);
        while (s[2:0] != 3'b000 && n < 40) begin
            rd(3'd3, s);
            n++;
        end
        check(req, {5'b0, s[2:0]}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        repeat (3) @(negedge sys_clk);
        sys_rst_n = 1'b1; tmr_rst_n = 1'b1;
        repeat (3) @(negedge sys_clk);

        // R10 reset state
        for (int a = 1; a < 6; a++) begin
            rd(a[2:0], v);
            check("R10", v, 8'h00);
        end
        check("R10 irq", {6'b0, irq_match, irq_ovf}, 8'h00);

        // R1 / R4: busy visible at once, holding value readable at once
        wr(3'd1, 8'h77);
        rd(3'd3, v);
        check("R1 busy cmp", v & 8'h07, 8'h02);
        rd(3'd1, v);
        check("R4 hold while busy", v, 8'h77);
        // R9: second write while busy is ignored
        wr(3'd1, 8'h11);
        rd(3'd1, v);
        check("R9 hold kept", v, 8'h77);
        rd(3'd3, v);
        check("R9 err set", v & 8'h08, 8'h08);
        wait_idle("R2 cmp");
        wr(3'd3, 8'h08);
        rd(3'd3, v);
        check("R9 err cleared", v, 8'h00);

        wr(3'd0, 8'h21);
        rd(3'd3, v);
        check("R1 busy cnt", v & 8'h07, 8'h04);
        wait_idle("R2 cnt");
        wr(3'd2, 8'h00);
        rd(3'd3, v);
        check("R1 busy ctl", v & 8'h07, 8'h01);
        wait_idle("R2 ctl");

        // table walk: write, wait for transfer, read back
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            if (VEC[i][18:16] < 3'd3) wait_idle("R2 vec");
            repeat (6) @(negedge sys_clk);
            rd(VEC[i][18:16], v);
            check(VEC[i][18:16] == 3'd0 ? "R3 vec" :
                  VEC[i][18:16] >= 3'd4 ? "R8/R6 vec" : "R4 vec", v, VEC[i][7:0]);
        end

        // R5 / R8: run through wrap and compare point
        wr(3'd0, 8'hFA); wait_idle("R2");
        wr(3'd1, 8'h05); wait_idle("R2");
        wr(3'd5, 8'h03);
        wr(3'd4, 8'h03);
        wr(3'd2, 8'h01); wait_idle("R2");
        rd(3'd0, v);
        repeat (5) @(negedge sys_clk);
        rd(3'd0, v2);
        check("R3 running changes", (v != v2) ? 8'h01 : 8'h00, 8'h01);
        repeat (30) @(negedge sys_clk);
        wr(3'd2, 8'h00); wait_idle("R2");
        repeat (6) @(negedge sys_clk);
        rd(3'd0, v);
        repeat (10) @(negedge sys_clk);
        rd(3'd0, v2);
        check("R3 stopped stable", v2, v);
        rd(3'd4, v);
        check("R5 flags", v, 8'h03);
        check("R8 gie off", {6'b0, irq_match, irq_ovf}, 8'h00);
        gie = 1'b1;
        #1 check("R8 gie on", {6'b0, irq_match, irq_ovf}, 8'h03);
        wr(3'd5, 8'h02);
        #1 check("R8 mask", {6'b0, irq_match, irq_ovf}, 8'h02);
        wr(3'd4, 8'h00);
        rd(3'd4, v);
        check("R6 zero write", v, 8'h03);
        wr(3'd4, 8'h02);
        rd(3'd4, v);
        check("R6 w1c", v, 8'h01);
        @(negedge sys_clk); ack_ovf = 1'b1;
        @(negedge sys_clk); ack_ovf = 1'b0;
        rd(3'd4, v);
        check("R7 ack", v, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule